// File: doc/BRIEF.md
# Automatic power mode downshift controller

This block paces the frame captures of an optical motion sensor core and lowers its sampling rate when the surface stops moving. It holds one of four operating levels: an active level and three successively deeper rest levels. Each level has its own frame period, and the block issues a single-cycle frame strobe at that period, together with an LED enable pulse that covers the capture. An idle timer counts the ticks spent in the current level without reported motion. When the timer reaches the dwell time set for that level, the block steps one level deeper. A motion pulse from the navigation core brings it straight back to the active level.

A 2-bit override field can pin the block to any rest level. Software uses it when the sensor is not needed for a while. A shutdown pin stops all activity at once, and only a reset clears that state. All periods and dwell times are parameters counted in system clock ticks, so the same code runs at real timing or at scaled timing.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While rst_ni is low and in the first cycle after its release, mode_o reads 00 (active level), frame_o is 0 and led_en_o is 0.
- R2: mode_o encodes the level: 00 active, 01 rest 1, 10 rest 2, 11 rest 3. With force_rest_i = 00 and no motion, the block leaves the active level after DWELL_RUN ticks, rest 1 after DWELL_R1 ticks and rest 2 after DWELL_R2 ticks, each time moving one level deeper. It stays in rest 3 indefinitely.
- R3: In automatic operation, a motion_i pulse puts mode_o at 00 on the next clock edge from any level, and the idle timer restarts from zero. DWELL_RUN full ticks then pass before the next downshift.
- R4: frame_o is high for one cycle at a time. Consecutive strobes within one level are exactly that level's period apart: PERIOD_RUN, PERIOD_R1, PERIOD_R2 or PERIOD_R3 ticks.
- R5: After a level change, the first strobe comes exactly one full period of the new level after the change. It is counted from the edge that changes mode_o.
- R6: A nonzero force_rest_i (01 rest 1, 10 rest 2, 11 rest 3) sets mode_o to that level on the next edge. The level is held with no downshift while the field stays nonzero, and motion_i has no effect on it.
- R7: When force_rest_i returns to 00 from a nonzero value, mode_o goes to 00 on the next edge, and automatic timing restarts from there.
- R8: led_en_o rises in the same cycle as each frame strobe and stays high for LED_CYCLES cycles.
- R9: While shutdown_i is high, frame_o and led_en_o are 0 in the same cycle, and mode_o is frozen regardless of motion_i and force_rest_i. This state persists after shutdown_i falls, until rst_ni is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| motion_i | input | 1 | Motion detected pulse from the navigation core |
| force_rest_i | input | 2 | Override level: 00 automatic, 01..11 hold rest 1..3 |
| shutdown_i | input | 1 | Shutdown request, active high, sticky until reset |
| frame_o | output | 1 | Single-cycle frame trigger strobe |
| mode_o | output | 2 | Current level: 00 active, 01..11 rest 1..3 |
| led_en_o | output | 1 | LED enable pulse for each frame |

## Verification
The bench builds the block with frame periods of 4, 6, 10 and 16 ticks, dwell times of 20, 30 and 50 ticks, and a 2-cycle LED pulse. With these values the whole downshift chain down to rest 3 completes within about a hundred cycles. Every tick of each dwell can be checked at its exact boundary. The forced field is used to park the block in each rest level, so that both the first-strobe delay and the steady period of every level can be measured. The shutdown test holds the block in rest 1 and toggles motion and the forced field throughout. It then confirms that the outputs stay silent, both during shutdown and after its release, until a reset is applied.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_REST1 = 2'd1,
    MODE_REST2 = 2'd2,
    MODE_REST3 = 2'd3
  } pwr_mode_e;
endpackage

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
#(
  parameter int unsigned DWELL_RUN = 237000,
  parameter int unsigned DWELL_R1  = 8400000,
  parameter int unsigned DWELL_R2  = 504000000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       motion_i,
  input  logic [1:0] force_rest_i,
  input  logic       shutdown_i,
  output pwr_mode_e  mode_o,
  output logic       restart_o,
  output logic       stop_o
);
  localparam int unsigned DWELL_MAX =
    (DWELL_RUN > DWELL_R1) ? ((DWELL_RUN > DWELL_R2) ? DWELL_RUN : DWELL_R2)
                           : ((DWELL_R1 > DWELL_R2) ? DWELL_R1 : DWELL_R2);
  localparam int IDLE_W = $clog2(DWELL_MAX + 1);
  localparam logic [IDLE_W-1:0] IDLE_TOP = IDLE_W'(DWELL_MAX);

  pwr_mode_e         mode_q, mode_d;
  logic [IDLE_W-1:0] idle_q;
  logic              forced_q, halted_q, clr_idle, forcing;

  function automatic logic [IDLE_W-1:0] dwell_last(pwr_mode_e m);
    case (m)
      MODE_RUN:   return IDLE_W'(DWELL_RUN - 1);
      MODE_REST1: return IDLE_W'(DWELL_R1 - 1);
      MODE_REST2: return IDLE_W'(DWELL_R2 - 1);
      default:    return IDLE_TOP;
    endcase
  endfunction

  assign stop_o  = shutdown_i | halted_q;
  assign forcing = force_rest_i != 2'b00;

  always_comb begin
    mode_d   = mode_q;
    clr_idle = 1'b0;
    if (forcing) begin
      mode_d = pwr_mode_e'(force_rest_i);
    end else if (forced_q) begin
      mode_d = MODE_RUN;
    end else if (motion_i) begin
      mode_d   = MODE_RUN;
      clr_idle = 1'b1;
    end else if (mode_q != MODE_REST3 && idle_q == dwell_last(mode_q)) begin
      mode_d = pwr_mode_e'(mode_q + 2'd1);
    end
    if (mode_d != mode_q) clr_idle = 1'b1;
  end

  assign restart_o = ~stop_o & (mode_d != mode_q);
  assign mode_o    = mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_RUN;
      idle_q   <= '0;
      forced_q <= 1'b0;
      halted_q <= 1'b0;
    end else begin
      halted_q <= halted_q | shutdown_i;
      if (!stop_o) begin
        mode_q   <= mode_d;
        forced_q <= forcing;
        if (clr_idle)             idle_q <= '0;
        else if (idle_q != IDLE_TOP) idle_q <= idle_q + 1'b1;
      end
    end
  end

  assert_motion_wake_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (motion_i && !forcing && !forced_q && !stop_o) |=> (mode_q == MODE_RUN));

  assert_force_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (forcing && !stop_o) |=> (mode_q == pwr_mode_e'($past(force_rest_i))));

  // automatic operation only ever steps one level deeper
  assert_single_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stop_o && !forcing && !forced_q && !motion_i) |=>
      (mode_q == $past(mode_q)) || (mode_q == $past(mode_q) + 2'd1 && $past(mode_q) != MODE_REST3));

  assert_halt_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_q |=> $stable(mode_q));
endmodule

// File: rtl/pwr_frame_timer.sv
module pwr_frame_timer
  import pwr_mode_pkg::*;
#(
  parameter int unsigned PERIOD_RUN = 10000,
  parameter int unsigned PERIOD_R1  = 16500,
  parameter int unsigned PERIOD_R2  = 82000,
  parameter int unsigned PERIOD_R3  = 410000
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  pwr_mode_e mode_i,
  input  logic      restart_i,
  input  logic      stop_i,
  output logic      frame_o
);
  localparam int unsigned PER_MAX =
    (PERIOD_RUN > PERIOD_R1) ? ((PERIOD_RUN > PERIOD_R2) ? ((PERIOD_RUN > PERIOD_R3) ? PERIOD_RUN : PERIOD_R3)
                                                         : ((PERIOD_R2 > PERIOD_R3) ? PERIOD_R2 : PERIOD_R3))
                             : ((PERIOD_R1 > PERIOD_R2) ? ((PERIOD_R1 > PERIOD_R3) ? PERIOD_R1 : PERIOD_R3)
                                                        : ((PERIOD_R2 > PERIOD_R3) ? PERIOD_R2 : PERIOD_R3));
  localparam int PER_W = $clog2(PER_MAX + 1);

  logic [PER_W-1:0] cnt_q;
  logic             tick;

  function automatic logic [PER_W-1:0] period_last(pwr_mode_e m);
    case (m)
      MODE_RUN:   return PER_W'(PERIOD_RUN - 1);
      MODE_REST1: return PER_W'(PERIOD_R1 - 1);
      MODE_REST2: return PER_W'(PERIOD_R2 - 1);
      default:    return PER_W'(PERIOD_R3 - 1);
    endcase
  endfunction

  assign tick    = cnt_q == period_last(mode_i);
  assign frame_o = tick & ~stop_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (restart_i)  cnt_q <= '0;
    else if (!stop_i)    cnt_q <= tick ? '0 : cnt_q + 1'b1;
  end

  // periods are at least two ticks
  assert_strobe_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |=> !frame_o);

  assert_no_strobe_after_change_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !frame_o);
endmodule

// File: rtl/pwr_led_pulse.sv
module pwr_led_pulse #(
  parameter int unsigned LED_CYCLES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_i,
  input  logic stop_i,
  output logic led_o
);
  localparam int LW = $clog2(LED_CYCLES + 1);
  localparam logic [LW-1:0] HOLD = LW'(LED_CYCLES - 1);

  logic [LW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (stop_i)       cnt_q <= '0;
    else if (frame_i)      cnt_q <= HOLD;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign led_o = ~stop_i & (frame_i | (cnt_q != '0));

  assert_led_follows_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && !stop_i) |-> led_o);
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int unsigned PERIOD_RUN = 10000,
  parameter int unsigned PERIOD_R1  = 16500,
  parameter int unsigned PERIOD_R2  = 82000,
  parameter int unsigned PERIOD_R3  = 410000,
  parameter int unsigned DWELL_RUN  = 237000,
  parameter int unsigned DWELL_R1   = 8400000,
  parameter int unsigned DWELL_R2   = 504000000,
  parameter int unsigned LED_CYCLES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       motion_i,
  input  logic [1:0] force_rest_i,
  input  logic       shutdown_i,
  output logic       frame_o,
  output logic [1:0] mode_o,
  output logic       led_en_o
);
  pwr_mode_e mode;
  logic      restart, stop;

  pwr_mode_fsm #(
    .DWELL_RUN(DWELL_RUN), .DWELL_R1(DWELL_R1), .DWELL_R2(DWELL_R2)
  ) u_fsm (
    .clk_i, .rst_ni, .motion_i, .force_rest_i, .shutdown_i,
    .mode_o(mode), .restart_o(restart), .stop_o(stop)
  );

  pwr_frame_timer #(
    .PERIOD_RUN(PERIOD_RUN), .PERIOD_R1(PERIOD_R1),
    .PERIOD_R2(PERIOD_R2), .PERIOD_R3(PERIOD_R3)
  ) u_timer (
    .clk_i, .rst_ni, .mode_i(mode), .restart_i(restart), .stop_i(stop),
    .frame_o
  );

  pwr_led_pulse #(.LED_CYCLES(LED_CYCLES)) u_led (
    .clk_i, .rst_ni, .frame_i(frame_o), .stop_i(stop), .led_o(led_en_o)
  );

  assign mode_o = mode;

  assert_shutdown_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_i |-> (!frame_o && !led_en_o));
endmodule

// File: tb/pwr_mode_ctrl_tb.sv
module pwr_mode_ctrl_tb;
  localparam int P_RUN = 4, P_R1 = 6, P_R2 = 10, P_R3 = 16;
  localparam int D_RUN = 20, D_R1 = 30, D_R2 = 50;
  localparam int LEDC  = 2;

  logic       clk_i = 1'b0, rst_ni = 1'b0, motion_i = 1'b0, shutdown_i = 1'b0;
  logic [1:0] force_rest_i = 2'b00;
  logic       frame_o, led_en_o;
  logic [1:0] mode_o;
  int checks = 0, errors = 0, cyc = 0;

  always #5 clk_i = ~clk_i;

  pwr_mode_ctrl #(
    .PERIOD_RUN(P_RUN), .PERIOD_R1(P_R1), .PERIOD_R2(P_R2), .PERIOD_R3(P_R3),
    .DWELL_RUN(D_RUN), .DWELL_R1(D_R1), .DWELL_R2(D_R2), .LED_CYCLES(LEDC)
  ) u_dut (.*);

  typedef struct packed {
    logic [1:0] frc;
    logic       mot;
    logic [7:0] cyc;
    logic [1:0] exp_mode;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 8'd19,  2'd0, 4'd2},  // R2 active dwell
    '{2'd0, 1'b0, 8'd1,   2'd1, 4'd2},
    '{2'd0, 1'b0, 8'd29,  2'd1, 4'd2},
    '{2'd0, 1'b0, 8'd1,   2'd2, 4'd2},
    '{2'd0, 1'b0, 8'd49,  2'd2, 4'd2},
    '{2'd0, 1'b0, 8'd1,   2'd3, 4'd2},
    '{2'd0, 1'b0, 8'd100, 2'd3, 4'd2},  // rest 3 is terminal
    '{2'd0, 1'b1, 8'd1,   2'd0, 4'd3},  // R3 wake from rest 3
    '{2'd0, 1'b0, 8'd19,  2'd0, 4'd3},
    '{2'd0, 1'b0, 8'd1,   2'd1, 4'd3},
    '{2'd0, 1'b0, 8'd29,  2'd1, 4'd2},
    '{2'd0, 1'b0, 8'd1,   2'd2, 4'd2},
    '{2'd0, 1'b1, 8'd1,   2'd0, 4'd3},  // wake from rest 2
    '{2'd2, 1'b0, 8'd1,   2'd2, 4'd6},  // R6 forced
    '{2'd2, 1'b1, 8'd1,   2'd2, 4'd6},  // motion ignored
    '{2'd2, 1'b0, 8'd200, 2'd2, 4'd6},  // no downshift
    '{2'd3, 1'b0, 8'd1,   2'd3, 4'd6},
    '{2'd1, 1'b0, 8'd1,   2'd1, 4'd6},
    '{2'd0, 1'b0, 8'd1,   2'd0, 4'd7},  // R7 release to active
    '{2'd0, 1'b0, 8'd19,  2'd0, 4'd7},
    '{2'd0, 1'b0, 8'd1,   2'd1, 4'd7}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; motion_i = 1'b0; force_rest_i = 2'b00; shutdown_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check(mode_o == 2'd0 && !frame_o && !led_en_o, "R1", "reset state",
          {mode_o, frame_o, led_en_o}, 0);
    rst_ni = 1'b1;
    #1;
    check(mode_o == 2'd0 && !frame_o && !led_en_o, "R1", "after release",
          {mode_o, frame_o, led_en_o}, 0);
  endtask

  task automatic wait_frame(output int n);
    n = 0;
    do begin
      @(negedge clk_i);
      n++;
    end while (!frame_o && n < 200);
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n, frames, leds;
    logic [1:0] held;

    do_reset();
    // table walk: downshift, wake, force and release
    for (int i = 0; i < NV; i++) begin
      force_rest_i = VECS[i].frc;
      motion_i     = VECS[i].mot;
      @(negedge clk_i);
      motion_i = 1'b0;
      for (int k = 1; k < int'(VECS[i].cyc); k++) @(negedge clk_i);
      checks++;
      if (mode_o != VECS[i].exp_mode) begin
        errors++;
        $display("FAIL R%0d vector %0d mode: actual %0d expected %0d",
                 VECS[i].req, i, mode_o, VECS[i].exp_mode);
      end
    end

    // R4 active period and single-cycle strobe, R8 LED pulse
    do_reset();
    wait_frame(n);
    wait_frame(n);
    check(n == P_RUN, "R4", "active period", n, P_RUN);
    check(led_en_o == 1'b1, "R8", "led with strobe", led_en_o, 1);
    @(negedge clk_i);
    check(frame_o == 1'b0, "R4", "strobe width", frame_o, 0);
    check(led_en_o == 1'b1, "R8", "led second cycle", led_en_o, 1);
    @(negedge clk_i);
    check(led_en_o == 1'b0, "R8", "led end", led_en_o, 0);

    // R5 first strobe after change, R4 steady period per rest level
    wait_frame(n);
    force_rest_i = 2'd3;
    wait_frame(n);
    check(n == P_R3, "R5", "first strobe rest3", n, P_R3);
    wait_frame(n);
    check(n == P_R3, "R4", "rest3 period", n, P_R3);
    force_rest_i = 2'd1;
    wait_frame(n);
    check(n == P_R1, "R5", "first strobe rest1", n, P_R1);
    wait_frame(n);
    check(n == P_R1, "R4", "rest1 period", n, P_R1);
    force_rest_i = 2'd2;
    wait_frame(n);
    check(n == P_R2, "R5", "first strobe rest2", n, P_R2);
    wait_frame(n);
    check(n == P_R2, "R4", "rest2 period", n, P_R2);

    // R9 shutdown is silent and sticky until reset
    do_reset();
    repeat (25) @(negedge clk_i);
    held = mode_o;
    check(held == 2'd1, "R9", "setup rest1", held, 1);
    shutdown_i = 1'b1;
    #1;
    check(!frame_o && !led_en_o, "R9", "same-cycle quiet", {frame_o, led_en_o}, 0);
    frames = 0; leds = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk_i);
      motion_i = k[0];
      force_rest_i = (k > 30) ? 2'd3 : 2'd0;
      frames += int'(frame_o); leds += int'(led_en_o);
    end
    check(frames == 0 && leds == 0, "R9", "quiet during shutdown", frames + leds, 0);
    check(mode_o == held, "R9", "mode frozen", mode_o, held);
    shutdown_i = 1'b0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk_i);
      motion_i = k[1];
      force_rest_i = (k > 30) ? 2'd0 : 2'd2;
      frames += int'(frame_o); leds += int'(led_en_o);
    end
    check(frames == 0 && leds == 0, "R9", "quiet after release", frames + leds, 0);
    check(mode_o == held, "R9", "mode frozen after release", mode_o, held);
    do_reset();
    wait_frame(n);
    wait_frame(n);
    check(n == P_RUN, "R9", "strobes resume after reset", n, P_RUN);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule